// File: doc/BRIEF.md
# Two-stage timebase watchdog timer

This peripheral watches for software that has stopped running. It holds an interval counter that spans 2^N clock cycles. When an interval ends without service, the block first gives a warning: it sets a state flag and drives an interrupt level. If the next interval also ends while that flag is still set, the block emits a one-cycle reset pulse and records the event in a sticky reset-status flag. Software services the watchdog by writing a one to the state-flag bit. That write clears the warning and starts a new interval from zero.

Software reaches the block through a plain 32-bit register port with a byte address, a write strobe and a read strobe. Two control words each hold one enable bit, and the watchdog runs while either bit is set. Stopping it therefore takes two writes. A third word returns a free-running timebase count that advances every clock. Software can read it twice and check that the clock is alive.

Top module: `twostage_wdog`

## Requirements
- R1: After reset, every flag, both enable bits, the interval count, the timebase, `irq`, `wdt_reset` and `bus_rdata` are zero.
- R2: The control word at byte offset 0x0 has these fields:
  - bit 1: enable A (read/write)
  - bit 2: state flag
  - bit 3: reset-status flag

  The control word at offset 0x4 holds enable B in bit 0. All other bits read as zero. Read data is registered and appears on `bus_rdata` in the cycle after the `bus_rd` strobe. It holds until the next read.
- R3: The word at offset 0x8 is a timebase that increments by one on every clock, modulo 2^32. Two reads on consecutive cycles return values that differ by one.
- R4: The interval counter advances while enable A or enable B is 1. When both are 0, the counter returns to zero and no expiry occurs.
- R5: An interval expires on the 2^N-th clock edge after counting starts from zero. An expiry while the state flag is clear sets the flag and produces no reset.
- R6: An expiry while the state flag is set drives `wdt_reset` high for exactly one cycle and sets the reset-status flag in that same cycle. The state flag stays set.
- R7: A write to offset 0x0 with bit 2 = 1 clears the state flag and restarts the interval from zero. This write wins over an expiry in the same cycle.
- R8: A write to offset 0x0 with bit 3 = 1 clears the reset-status flag. Writing 0 to bit 2 or bit 3 leaves that flag unchanged.
- R9: `irq` is a level that equals the state flag.
- R10: Writes to any offset other than 0x0 and 0x4 have no effect. Reads from any offset other than 0x0, 0x4 and 0x8 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Warning interrupt level after the first expiry |
| wdt_reset | output | 1 | One-cycle reset pulse on the second expiry |

## Verification
Every result of this block comes out of one register stage:
- Read data, the flags and `irq` change at the clock edge that samples the strobe or the expiry.
- Expiry itself falls on the 2^N-th edge after the enable write or the service write.

The bench drives its inputs on the falling edge. It advances a behavioural model on the rising edge and compares `irq`, `wdt_reset` and `bus_rdata` with the model on the next falling edge, so each result is checked in the first cycle it is due. The directed checks count edges from the write that starts an interval. They sample one edge before and exactly at the expected expiry, and they place a service write on the expiry edge itself to test which of the two takes priority.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // byte offsets of the three words
  localparam int unsigned OFS_CTRL_A = 0;
  localparam int unsigned OFS_CTRL_B = 4;
  localparam int unsigned OFS_TBASE  = 8;
  // field positions in the control words
  localparam int unsigned BIT_ENA_A  = 1;
  localparam int unsigned BIT_STATE  = 2;
  localparam int unsigned BIT_RSTST  = 3;
  localparam int unsigned BIT_ENA_B  = 0;
endpackage

// File: rtl/wdog_timebase.sv
module wdog_timebase #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] count
);
  logic [W-1:0] count_nxt;

  always_comb begin
    count_nxt = count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_nxt;
  end
endmodule

// File: rtl/wdog_interval.sv
module wdog_interval #(
  parameter int unsigned N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         restart,
  output logic         expire,
  output logic [N-1:0] count
);
  localparam logic [N-1:0] CNT_LAST = {N{1'b1}};

  logic [N-1:0] count_nxt;
  logic         count_ce;

  always_comb begin
    expire    = run && (count == CNT_LAST);
    count_ce  = run || restart || (count != '0);
    if (!run || restart) count_nxt = '0;
    else                 count_nxt = count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count <= '0;
    else if (count_ce) count <= count_nxt;
  end
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  input  logic          expire,
  input  logic [DW-1:0] tb_value,
  output logic          run,
  output logic          service,
  output logic          state_flag,
  output logic          rst_flag,
  output logic          wdt_reset,
  output logic [DW-1:0] bus_rdata
);
  logic          en_a_q, en_b_q, pulse_q;
  logic          en_a_nxt, en_b_nxt, state_nxt, rflag_nxt, pulse_nxt;
  logic          hit_a, hit_b, hit_t, wr_a, wr_b, fire;
  logic [DW-1:0] rd_value, rdata_nxt;
  logic          rdata_ce;

  always_comb begin
    hit_a   = (bus_addr == AW'(OFS_CTRL_A));
    hit_b   = (bus_addr == AW'(OFS_CTRL_B));
    hit_t   = (bus_addr == AW'(OFS_TBASE));
    wr_a    = bus_wr && hit_a;
    wr_b    = bus_wr && hit_b;
    service = wr_a && bus_wdata[BIT_STATE];
    fire    = expire && state_flag && !service;

    en_a_nxt = wr_a ? bus_wdata[BIT_ENA_A] : en_a_q;
    en_b_nxt = wr_b ? bus_wdata[BIT_ENA_B] : en_b_q;

    if (service)     state_nxt = 1'b0;
    else if (expire) state_nxt = 1'b1;
    else             state_nxt = state_flag;

    if (fire)                            rflag_nxt = 1'b1;
    else if (wr_a && bus_wdata[BIT_RSTST]) rflag_nxt = 1'b0;
    else                                 rflag_nxt = rst_flag;

    pulse_nxt = fire;

    rd_value = '0;
    if (hit_a) begin
      rd_value[BIT_ENA_A] = en_a_q;
      rd_value[BIT_STATE] = state_flag;
      rd_value[BIT_RSTST] = rst_flag;
    end else if (hit_b) begin
      rd_value[BIT_ENA_B] = en_b_q;
    end else if (hit_t) begin
      rd_value = tb_value;
    end
    rdata_ce  = bus_rd;
    rdata_nxt = rd_value;

    run       = en_a_q || en_b_q;
    wdt_reset = pulse_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_a_q     <= 1'b0;
      en_b_q     <= 1'b0;
      state_flag <= 1'b0;
      rst_flag   <= 1'b0;
      pulse_q    <= 1'b0;
    end else begin
      en_a_q     <= en_a_nxt;
      en_b_q     <= en_b_nxt;
      state_flag <= state_nxt;
      rst_flag   <= rflag_nxt;
      pulse_q    <= pulse_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        bus_rdata <= '0;
    else if (rdata_ce) bus_rdata <= rdata_nxt;
  end
endmodule

// File: rtl/twostage_wdog.sv
module twostage_wdog #(
  parameter int unsigned DATA_W        = 32,
  parameter int unsigned ADDR_W        = 4,
  parameter int unsigned INTERVAL_LOG2 = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              wdt_reset
);
  logic                     run_w, svc_w, expire_w, state_w, rflag_w;
  logic [INTERVAL_LOG2-1:0] cnt_w;
  logic [DATA_W-1:0]        tb_w;

  wdog_timebase #(.W(DATA_W)) tbase_i (
    .clk   (clk),
    .rst_n (rst_n),
    .count (tb_w)
  );

  wdog_interval #(.N(INTERVAL_LOG2)) ival_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run_w),
    .restart (svc_w),
    .expire  (expire_w),
    .count   (cnt_w)
  );

  wdog_regs #(.DW(DATA_W), .AW(ADDR_W)) regs_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .expire     (expire_w),
    .tb_value   (tb_w),
    .run        (run_w),
    .service    (svc_w),
    .state_flag (state_w),
    .rst_flag   (rflag_w),
    .wdt_reset  (wdt_reset),
    .bus_rdata  (bus_rdata)
  );

  always_comb irq = state_w;
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
  parameter int unsigned N  = 6,
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          run,
  input logic          expire,
  input logic [N-1:0]  cnt,
  input logic          state_flag,
  input logic          rst_flag,
  input logic          wdt_reset,
  input logic [DW-1:0] tb
);
  assert_pulse_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset |=> !wdt_reset);

  assert_pulse_sets_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset |-> rst_flag);

  assert_pulse_after_warning_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && wdt_reset) |-> $past(state_flag));

  assert_warning_on_expiry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $rose(state_flag)) |-> $past(expire));

  assert_idle_counter_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));

  assert_service_restarts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == '0 && bus_wdata[2]) |=> (!state_flag && cnt == '0));

  assert_timebase_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (tb == $past(tb) + 1'b1));
endmodule

bind twostage_wdog wdog_checker #(.N(INTERVAL_LOG2), .DW(DATA_W), .AW(ADDR_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .run        (run_w),
  .expire     (expire_w),
  .cnt        (cnt_w),
  .state_flag (state_w),
  .rst_flag   (rflag_w),
  .wdt_reset  (wdt_reset),
  .tb         (tb_w)
);

// File: tb/twostage_wdog_tb_top.sv
`timescale 1ns/1ps
module twostage_wdog_tb_top;
  localparam int NLOG = 5;
  localparam int PER  = 1 << NLOG;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, wdt_reset;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  twostage_wdog #(.DATA_W(32), .ADDR_W(4), .INTERVAL_LOG2(NLOG)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .wdt_reset(wdt_reset)
  );

  // behavioural reference model
  bit          m_en_a, m_en_b, m_state, m_rflag, m_pulse;
  int          m_cnt;
  logic [31:0] m_tb, m_rdata;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en_a = 0; m_en_b = 0; m_state = 0; m_rflag = 0; m_pulse = 0;
      m_cnt = 0; m_tb = '0; m_rdata = '0;
    end else begin
      bit on, exp, svc, fire;
      on   = m_en_a || m_en_b;
      exp  = on && (m_cnt == PER - 1);
      svc  = bus_wr && bus_addr == 4'h0 && bus_wdata[2];
      fire = exp && m_state && !svc;
      if (bus_rd) begin
        case (bus_addr)
          4'h0:    m_rdata = {28'd0, m_rflag, m_state, m_en_a, 1'b0};
          4'h4:    m_rdata = {31'd0, m_en_b};
          4'h8:    m_rdata = m_tb;
          default: m_rdata = '0;
        endcase
      end
      if (svc) m_state = 0; else if (exp) m_state = 1;
      if (fire) m_rflag = 1;
      else if (bus_wr && bus_addr == 4'h0 && bus_wdata[3]) m_rflag = 0;
      m_pulse = fire;
      m_cnt = (!on || svc) ? 0 : (m_cnt + 1) % PER;
      if (bus_wr && bus_addr == 4'h0) m_en_a = bus_wdata[1];
      if (bus_wr && bus_addr == 4'h4) m_en_b = bus_wdata[0];
      m_tb = m_tb + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R9 irq vs model", {31'd0, irq}, {31'd0, m_state});
      chk("R6 wdt_reset vs model", {31'd0, wdt_reset}, {31'd0, m_pulse});
      chk("R2 rdata vs model", bus_rdata, m_rdata);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v, t1, t2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    chk("R1 wdt_reset after reset", {31'd0, wdt_reset}, 32'd0);
    chk("R1 rdata after reset", bus_rdata, 32'd0);
    rd(4'h0, v); chk("R1 ctrl A after reset", v, 32'd0);
    rd(4'h4, v); chk("R1 ctrl B after reset", v, 32'd0);
    // R3 timebase
    rd(4'h8, t1); rd(4'h8, t2);
    chk("R3 timebase step", t2 - t1, 32'd1);
    // R10 unmapped offset
    wr(4'hC, 32'hFFFF_FFFF);
    rd(4'hC, v); chk("R10 unmapped read", v, 32'd0);
    rd(4'h0, v); chk("R10 ctrl A untouched", v, 32'd0);
    rd(4'h4, v); chk("R10 ctrl B untouched", v, 32'd0);
    // R4/R5 enable B alone, first expiry
    wr(4'h4, 32'h1);
    repeat (PER - 1) @(negedge clk);
    chk("R5 no warning before interval", {31'd0, irq}, 32'd0);
    @(negedge clk);
    chk("R5 warning at interval", {31'd0, irq}, 32'd1);
    chk("R5 no reset on first expiry", {31'd0, wdt_reset}, 32'd0);
    rd(4'h0, v); chk("R2 state flag readable", v, 32'h4);
    // R7 service
    wr(4'h0, 32'h4);
    chk("R7 service clears warning", {31'd0, irq}, 32'd0);
    repeat (PER - 1) @(negedge clk);
    chk("R7 interval restarted", {31'd0, irq}, 32'd0);
    for (int i = 0; i < 4 && !irq; i++) @(negedge clk);
    chk("R5 warning after restarted interval", {31'd0, irq}, 32'd1);
    // R6 second expiry
    repeat (PER - 1) @(negedge clk);
    chk("R6 no reset before second expiry", {31'd0, wdt_reset}, 32'd0);
    @(negedge clk);
    chk("R6 reset pulse", {31'd0, wdt_reset}, 32'd1);
    @(negedge clk);
    chk("R6 pulse single cycle", {31'd0, wdt_reset}, 32'd0);
    rd(4'h0, v); chk("R6 reset status set", v, 32'hC);
    // R8 clear reset status only
    wr(4'h0, 32'h8);
    rd(4'h0, v); chk("R8 status cleared, warning kept", v, 32'h4);
    // R4 disable needs both writes
    wr(4'h0, 32'h4);
    wr(4'h4, 32'h0);
    repeat (3 * PER) @(negedge clk);
    chk("R4 stopped watchdog idle", {31'd0, irq}, 32'd0);
    rd(4'h0, v); chk("R4 ctrl A idle", v, 32'd0);
    // R4 enable A alone
    wr(4'h0, 32'h2);
    repeat (PER) @(negedge clk);
    chk("R4 enable A counts", {31'd0, irq}, 32'd1);
    // R7 service on the expiry edge
    wr(4'h0, 32'h6);
    repeat (PER - 1) @(negedge clk);
    wr(4'h0, 32'h6);
    chk("R7 service beats expiry irq", {31'd0, irq}, 32'd0);
    chk("R7 service beats expiry reset", {31'd0, wdt_reset}, 32'd0);
    rd(4'h0, v); chk("R7 ctrl A after race", v, 32'h2);
    wr(4'h0, 32'h4);
    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule